// File: doc/BRIEF.md
# Class-of-Service Cache Way Mask Table

This block stores cache capacity masks for a set of service classes and turns the class of a hardware thread into way-enable masks for a shared cache. A register-style port, addressed by index, programs two things. The first is a table of L2 masks with one entry per class. The second is a bank of per-thread association registers, each holding the thread's active class. Every mask write is validated. A legal mask is a single contiguous run of ones that fits inside the mask width and is addressed to a class the table holds. Any other write leaves the stored state untouched and raises a one-cycle error pulse.

A lookup port takes a thread index. One cycle later it returns that thread's L2 way mask and an L3 way mask. The same class number indexes both tables. The L3 table is optional and may hold a different number of classes. A class above a table's own maximum yields an all-ones, unrestricted mask for that table. With code/data prioritization enabled, the L3 side keeps separate code and data masks, and the access type picks between them. With it disabled, the code mask serves both access types.

Address map with the default parameters: association registers at 0xC00 + thread, L3 code masks at 0xC40 + class, L3 data masks at 0xC80 + class, L2 masks at 0xD10 + class. Each window spans 64 indices.

Top module: `cos_mask_table`

## Requirements
- R1: After reset every mask entry is all ones within its width (L2 0xFF, L3 0xFFF by default), every association register holds class 0, cfg_err is low, and a lookup returns all-ones masks.
- R2: A write of a contiguous non-zero mask to a class within range is accepted with no error, and the entry reads back the written value one cycle after the read request (0x7F to L2 class 1 reads 0x7F).
- R3: A mask write of zero or with a non-contiguous pattern (for example 0x5A) is rejected. The entry keeps its value and cfg_err is high for exactly the one cycle after the write.
- R4: A mask write with any set bit at or above the table's mask width (for example 0x1FF to an 8-bit table) is rejected with the same error pulse and no change.
- R5: A mask write to a class index above the table's maximum class (L2 class 4 when the maximum is 3) is rejected with an error pulse.
- R6: A lookup returns the L2 mask of the class held by the addressed thread, on the cycle after the thread index is presented.
- R7: A class above the L2 maximum but within the L3 maximum gives an all-ones L2 mask while the L3 mask still comes from the L3 entry of that class.
- R8: With cdp_en high, lk_is_code=1 selects the L3 code mask and lk_is_code=0 the L3 data mask. With cdp_en low, the L3 code mask is returned for both.
- R9: An association write accepts any class up to the larger of the two table maxima (7 by default). A larger class, or a thread index beyond the thread count, is rejected with an error pulse and leaves the register unchanged.
- R10: A mask write accepted at one clock edge is seen by a lookup registered at the next edge. A lookup registered at the same edge still returns the old mask.
- R11: A read of an address outside all windows returns zero, and a write there is rejected with an error pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_rd_en | input | 1 | Register read strobe; data appears next cycle |
| cfg_addr | input | 12 | Register index |
| cfg_wdata | input | 16 | Write data |
| cfg_rdata | output | 16 | Registered read data, zero for unmapped addresses |
| cfg_err | output | 1 | One-cycle pulse after a rejected write |
| cdp_en | input | 1 | Enables separate L3 code and data masks |
| lk_thread | input | 2 | Thread index for a lookup |
| lk_is_code | input | 1 | Access type of the lookup: 1 code, 0 data |
| lk_l2_mask | output | 8 | Registered L2 way mask |
| lk_l3_mask | output | 12 | Registered L3 way mask |

## Verification
The assertions assume the two strobes are never high before reset has been released and synchronized, and that cfg_addr and cfg_wdata are stable around the sampling edge. The bench drives every input at the falling edge, lowers each strobe after one cycle and waits several cycles past reset before it issues any access. The range and contiguity properties on stored entries assume that software can fill the tables only through the write port. The bench therefore reaches every entry it inspects only by writes, reads and lookups at the ports.

// File: rtl/cos_pkg.sv
package cos_pkg;

  typedef enum logic [2:0] {
    RG_NONE,
    RG_ASSOC,
    RG_L2,
    RG_L3C,
    RG_L3D
  } region_e;

  localparam int WIN_SPAN = 64;

  // True when m holds one unbroken run of ones and is not zero.
  function automatic logic is_run(logic [31:0] m);
    logic [31:0] low;
    low = m & (~m + 32'd1);
    return (m != 32'd0) && (((m + low) & m) == 32'd0);
  endfunction

  function automatic logic in_win(logic [31:0] a, logic [31:0] base);
    return (a - base) < 32'(WIN_SPAN);
  endfunction

endpackage

// File: rtl/cos_mask_bank.sv
module cos_mask_bank #(
  parameter int MASK_W    = 8,
  parameter int MAX_CLASS = 3,
  parameter int DATA_W    = 16,
  parameter int CLS_W     = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CLS_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  output logic              wr_ok,
  input  logic [CLS_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data,
  input  logic [CLS_W-1:0]  lk_cls,
  output logic [MASK_W-1:0] lk_mask
);
  localparam int N = MAX_CLASS + 1;

  logic [MASK_W-1:0] ent_q [N];
  logic [MASK_W-1:0] ent_d [N];
  logic              idx_ok;
  logic              data_ok;
  logic              upd_en;

  always_comb begin
    idx_ok  = (32'(wr_idx) <= 32'(MAX_CLASS));
    data_ok = cos_pkg::is_run(32'(wr_data)) && ((32'(wr_data) >> MASK_W) == 32'd0);
    wr_ok   = idx_ok && data_ok;
    upd_en  = wr_en && wr_ok;
  end

  always_comb begin
    for (int i = 0; i < N; i++) begin
      ent_d[i] = ent_q[i];
      if (wr_idx == CLS_W'(i)) ent_d[i] = wr_data[MASK_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) ent_q[i] <= '1;
    end else if (upd_en) begin
      for (int i = 0; i < N; i++) ent_q[i] <= ent_d[i];
    end
  end

  always_comb begin
    rd_data = '0;
    lk_mask = '1;
    for (int i = 0; i < N; i++) begin
      if (rd_idx == CLS_W'(i)) rd_data = DATA_W'(ent_q[i]);
      if (lk_cls == CLS_W'(i)) lk_mask = ent_q[i];
    end
  end

  for (genvar g = 0; g < N; g++) begin : g_chk
    AST_ENTRY_IS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
      cos_pkg::is_run(32'(ent_q[g]))); // R3
    AST_REJECT_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !wr_ok) |=> $stable(ent_q[g])); // R4
  end

endmodule

// File: rtl/cos_assoc_regs.sv
module cos_assoc_regs #(
  parameter int NUM_THREADS = 4,
  parameter int MAX_CLASS   = 7,
  parameter int DATA_W      = 16,
  parameter int CLS_W       = 6,
  localparam int THR_W      = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CLS_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  output logic              wr_ok,
  input  logic [CLS_W-1:0]  rd_idx,
  output logic [CLS_W-1:0]  rd_cls,
  input  logic [THR_W-1:0]  lk_thread,
  output logic [CLS_W-1:0]  lk_cls
);
  logic [CLS_W-1:0] cls_q [NUM_THREADS];
  logic [CLS_W-1:0] cls_d [NUM_THREADS];
  logic             upd_en;

  always_comb begin
    wr_ok  = (32'(wr_idx) < 32'(NUM_THREADS)) && (32'(wr_data) <= 32'(MAX_CLASS));
    upd_en = wr_en && wr_ok;
    for (int i = 0; i < NUM_THREADS; i++) begin
      cls_d[i] = cls_q[i];
      if (wr_idx == CLS_W'(i)) cls_d[i] = wr_data[CLS_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_THREADS; i++) cls_q[i] <= '0;
    end else if (upd_en) begin
      for (int i = 0; i < NUM_THREADS; i++) cls_q[i] <= cls_d[i];
    end
  end

  always_comb begin
    rd_cls = '0;
    lk_cls = '0;
    for (int i = 0; i < NUM_THREADS; i++) begin
      if (rd_idx == CLS_W'(i)) rd_cls = cls_q[i];
      if (32'(lk_thread) == 32'(i)) lk_cls = cls_q[i];
    end
  end

  for (genvar g = 0; g < NUM_THREADS; g++) begin : g_chk
    AST_ASSOC_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      32'(cls_q[g]) <= 32'(MAX_CLASS)); // R9
  end

endmodule

// File: rtl/cos_mask_table.sv
module cos_mask_table #(
  parameter int NUM_THREADS = 4,
  parameter int L2_MASK_W   = 8,
  parameter int L2_MAX      = 3,
  parameter int L3_EN       = 1,
  parameter int L3_MASK_W   = 12,
  parameter int L3_MAX      = 7,
  parameter int DATA_W      = 16,
  parameter int ADDR_W      = 12,
  parameter logic [ADDR_W-1:0] ASSOC_BASE = 12'hC00,
  parameter logic [ADDR_W-1:0] L3C_BASE   = 12'hC40,
  parameter logic [ADDR_W-1:0] L3D_BASE   = 12'hC80,
  parameter logic [ADDR_W-1:0] L2_BASE    = 12'hD10,
  localparam int THR_W = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_wr_en,
  input  logic                 cfg_rd_en,
  input  logic [ADDR_W-1:0]    cfg_addr,
  input  logic [DATA_W-1:0]    cfg_wdata,
  output logic [DATA_W-1:0]    cfg_rdata,
  output logic                 cfg_err,
  input  logic                 cdp_en,
  input  logic [THR_W-1:0]     lk_thread,
  input  logic                 lk_is_code,
  output logic [L2_MASK_W-1:0] lk_l2_mask,
  output logic [L3_MASK_W-1:0] lk_l3_mask
);
  import cos_pkg::*;

  localparam int CLS_W     = 6;
  localparam int ASSOC_MAX = (L3_EN != 0 && L3_MAX > L2_MAX) ? L3_MAX : L2_MAX;

  // reset: asserted asynchronously, released on the clock
  logic rst_meta_q, rst_s_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_s_n    <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_s_n    <= rst_meta_q;
    end
  end

  // address decode
  region_e          region;
  logic [CLS_W-1:0] idx;
  always_comb begin
    region = RG_NONE;
    idx    = '0;
    if (in_win(32'(cfg_addr), 32'(ASSOC_BASE))) begin
      region = RG_ASSOC; idx = CLS_W'(cfg_addr - ASSOC_BASE);
    end else if (in_win(32'(cfg_addr), 32'(L3C_BASE))) begin
      region = RG_L3C;   idx = CLS_W'(cfg_addr - L3C_BASE);
    end else if (in_win(32'(cfg_addr), 32'(L3D_BASE))) begin
      region = RG_L3D;   idx = CLS_W'(cfg_addr - L3D_BASE);
    end else if (in_win(32'(cfg_addr), 32'(L2_BASE))) begin
      region = RG_L2;    idx = CLS_W'(cfg_addr - L2_BASE);
    end
  end

  logic                 as_ok, l2_ok, l3c_ok, l3d_ok;
  logic [CLS_W-1:0]     as_rd, cur_cls;
  logic [DATA_W-1:0]    l2_rd, l3c_rd, l3d_rd;
  logic [L2_MASK_W-1:0] l2_lk;
  logic [L3_MASK_W-1:0] l3c_lk, l3d_lk;

  cos_assoc_regs #(
    .NUM_THREADS(NUM_THREADS), .MAX_CLASS(ASSOC_MAX), .DATA_W(DATA_W), .CLS_W(CLS_W)
  ) assoc_i (
    .clk(clk), .rst_n(rst_s_n),
    .wr_en(cfg_wr_en && region == RG_ASSOC), .wr_idx(idx), .wr_data(cfg_wdata),
    .wr_ok(as_ok), .rd_idx(idx), .rd_cls(as_rd),
    .lk_thread(lk_thread), .lk_cls(cur_cls)
  );

  cos_mask_bank #(
    .MASK_W(L2_MASK_W), .MAX_CLASS(L2_MAX), .DATA_W(DATA_W), .CLS_W(CLS_W)
  ) l2_i (
    .clk(clk), .rst_n(rst_s_n),
    .wr_en(cfg_wr_en && region == RG_L2), .wr_idx(idx), .wr_data(cfg_wdata),
    .wr_ok(l2_ok), .rd_idx(idx), .rd_data(l2_rd),
    .lk_cls(cur_cls), .lk_mask(l2_lk)
  );

  if (L3_EN != 0) begin : g_l3
    cos_mask_bank #(
      .MASK_W(L3_MASK_W), .MAX_CLASS(L3_MAX), .DATA_W(DATA_W), .CLS_W(CLS_W)
    ) code_i (
      .clk(clk), .rst_n(rst_s_n),
      .wr_en(cfg_wr_en && region == RG_L3C), .wr_idx(idx), .wr_data(cfg_wdata),
      .wr_ok(l3c_ok), .rd_idx(idx), .rd_data(l3c_rd),
      .lk_cls(cur_cls), .lk_mask(l3c_lk)
    );
    cos_mask_bank #(
      .MASK_W(L3_MASK_W), .MAX_CLASS(L3_MAX), .DATA_W(DATA_W), .CLS_W(CLS_W)
    ) data_i (
      .clk(clk), .rst_n(rst_s_n),
      .wr_en(cfg_wr_en && region == RG_L3D), .wr_idx(idx), .wr_data(cfg_wdata),
      .wr_ok(l3d_ok), .rd_idx(idx), .rd_data(l3d_rd),
      .lk_cls(cur_cls), .lk_mask(l3d_lk)
    );
  end else begin : g_no_l3
    assign l3c_ok = 1'b0;
    assign l3d_ok = 1'b0;
    assign l3c_rd = '0;
    assign l3d_rd = '0;
    assign l3c_lk = '1;
    assign l3d_lk = '1;
  end

  // next state
  logic                 sel_ok, err_d;
  logic [DATA_W-1:0]    rdata_d;
  logic [L3_MASK_W-1:0] l3_sel;
  always_comb begin
    sel_ok  = 1'b0;
    rdata_d = '0;
    unique case (region)
      RG_ASSOC: begin sel_ok = as_ok;  rdata_d = DATA_W'(as_rd); end
      RG_L2:    begin sel_ok = l2_ok;  rdata_d = l2_rd;          end
      RG_L3C:   begin sel_ok = l3c_ok; rdata_d = l3c_rd;         end
      RG_L3D:   begin sel_ok = l3d_ok; rdata_d = l3d_rd;         end
      default:  begin sel_ok = 1'b0;   rdata_d = '0;             end
    endcase
    err_d  = cfg_wr_en && !sel_ok;
    l3_sel = (cdp_en && !lk_is_code) ? l3d_lk : l3c_lk;
  end

  // registers
  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      cfg_rdata  <= '0;
      cfg_err    <= 1'b0;
      lk_l2_mask <= '1;
      lk_l3_mask <= '1;
    end else begin
      if (cfg_rd_en) cfg_rdata <= rdata_d;
      cfg_err    <= err_d;
      lk_l2_mask <= l2_lk;
      lk_l3_mask <= l3_sel;
    end
  end

  AST_ERR_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_s_n)
    cfg_err |-> $past(cfg_wr_en)); // R3
  AST_L2_OPEN_ABOVE_MAX: assert property (@(posedge clk) disable iff (!rst_s_n)
    (32'(cur_cls) > 32'(L2_MAX)) |=> (lk_l2_mask == '1)); // R7
  AST_UNMAPPED_ERRS: assert property (@(posedge clk) disable iff (!rst_s_n)
    (cfg_wr_en && region == RG_NONE) |=> cfg_err); // R11

endmodule

// File: tb/cos_mask_table_tb_top.sv
module cos_mask_table_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_wr_en, cfg_rd_en, cdp_en, lk_is_code;
  logic [11:0] cfg_addr;
  logic [15:0] cfg_wdata, cfg_rdata;
  logic        cfg_err;
  logic [1:0]  lk_thread;
  logic [7:0]  lk_l2_mask;
  logic [11:0] lk_l3_mask;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cos_mask_table dut_i (
    .clk(clk), .rst_n(rst_n),
    .cfg_wr_en(cfg_wr_en), .cfg_rd_en(cfg_rd_en), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .cfg_err(cfg_err),
    .cdp_en(cdp_en), .lk_thread(lk_thread), .lk_is_code(lk_is_code),
    .lk_l2_mask(lk_l2_mask), .lk_l3_mask(lk_l3_mask)
  );

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  // write; returns the error flag seen the cycle after
  task automatic wr(input logic [11:0] a, input logic [15:0] d, output logic err);
    @(negedge clk);
    cfg_wr_en = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_wr_en = 1'b0;
    err = cfg_err;
  endtask

  task automatic rd(input logic [11:0] a, output logic [15:0] d);
    @(negedge clk);
    cfg_rd_en = 1'b1; cfg_addr = a;
    @(negedge clk);
    cfg_rd_en = 1'b0;
    d = cfg_rdata;
  endtask

  task automatic look(input logic [1:0] t, input logic code);
    @(negedge clk);
    lk_thread = t; lk_is_code = code;
    @(negedge clk);
  endtask

  task automatic t_reset();
    logic [15:0] d;
    check("R1 err idle", 32'(cfg_err), 0);
    for (int c = 0; c < 4; c++) begin
      rd(12'hD10 + 12'(c), d);
      check("R1 l2 entry", 32'(d), 32'hFF);
    end
    rd(12'hC40, d); check("R1 l3 code entry", 32'(d), 32'hFFF);
    rd(12'hC87, d); check("R1 l3 data entry", 32'(d), 32'hFFF);
    rd(12'hC03, d); check("R1 assoc class", 32'(d), 0);
    look(2'd0, 1'b1);
    check("R1 lookup l2", 32'(lk_l2_mask), 32'hFF);
    check("R1 lookup l3", 32'(lk_l3_mask), 32'hFFF);
  endtask

  task automatic t_write();
    logic e; logic [15:0] d;
    wr(12'hD11, 16'h007F, e); check("R2 no err", 32'(e), 0);
    rd(12'hD11, d);           check("R2 readback", 32'(d), 32'h7F);
    wr(12'hD12, 16'h003C, e); check("R2 no err mid run", 32'(e), 0);
    rd(12'hD12, d);           check("R2 readback mid run", 32'(d), 32'h3C);
  endtask

  task automatic t_bad();
    logic e; logic [15:0] d;
    wr(12'hD11, 16'h0000, e); check("R3 zero err", 32'(e), 1);
    @(negedge clk);           check("R3 pulse one cycle", 32'(cfg_err), 0);
    wr(12'hD11, 16'h005A, e); check("R3 gap err", 32'(e), 1);
    rd(12'hD11, d);           check("R3 unchanged", 32'(d), 32'h7F);
    wr(12'hD11, 16'h01FF, e); check("R4 wide err", 32'(e), 1);
    rd(12'hD11, d);           check("R4 unchanged", 32'(d), 32'h7F);
    wr(12'hD14, 16'h0001, e); check("R5 class range err", 32'(e), 1);
    wr(12'hC48, 16'h0001, e); check("R5 l3 class range err", 32'(e), 1);
  endtask

  task automatic t_lookup();
    logic e;
    wr(12'hC02, 16'd1, e); check("R9 assoc ok", 32'(e), 0);
    look(2'd2, 1'b1);      check("R6 lookup class1", 32'(lk_l2_mask), 32'h7F);
    look(2'd3, 1'b1);      check("R6 lookup class0", 32'(lk_l2_mask), 32'hFF);
    // same-edge write and lookup
    @(negedge clk);
    cfg_wr_en = 1'b1; cfg_addr = 12'hD11; cfg_wdata = 16'h000F; lk_thread = 2'd2;
    @(negedge clk);
    cfg_wr_en = 1'b0;
    check("R10 old at same edge", 32'(lk_l2_mask), 32'h7F);
    @(negedge clk);
    check("R10 new next edge", 32'(lk_l2_mask), 32'h0F);
  endtask

  task automatic t_over();
    logic e; logic [15:0] d;
    wr(12'hC45, 16'h00F0, e); check("R7 l3 write", 32'(e), 0);
    wr(12'hC01, 16'd5, e);    check("R9 class 5 ok", 32'(e), 0);
    look(2'd1, 1'b1);
    check("R7 l2 open", 32'(lk_l2_mask), 32'hFF);
    check("R7 l3 indexed", 32'(lk_l3_mask), 32'h0F0);
    wr(12'hC01, 16'd8, e);    check("R9 class 8 err", 32'(e), 1);
    rd(12'hC01, d);           check("R9 unchanged", 32'(d), 5);
    wr(12'hC04, 16'd1, e);    check("R9 thread range err", 32'(e), 1);
  endtask

  task automatic t_cdp();
    logic e;
    wr(12'hC85, 16'h000F, e); check("R8 data write", 32'(e), 0);
    cdp_en = 1'b1;
    look(2'd1, 1'b0); check("R8 data sel", 32'(lk_l3_mask), 32'h00F);
    look(2'd1, 1'b1); check("R8 code sel", 32'(lk_l3_mask), 32'h0F0);
    cdp_en = 1'b0;
    look(2'd1, 1'b0); check("R8 cdp off", 32'(lk_l3_mask), 32'h0F0);
  endtask

  task automatic t_unmapped();
    logic e; logic [15:0] d;
    rd(12'h100, d);           check("R11 read zero", 32'(d), 0);
    wr(12'h100, 16'h0001, e); check("R11 write err", 32'(e), 1);
  endtask

  initial begin
    rst_n = 1'b0; cfg_wr_en = 1'b0; cfg_rd_en = 1'b0; cfg_addr = '0;
    cfg_wdata = '0; cdp_en = 1'b0; lk_thread = '0; lk_is_code = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_write();
    t_bad();
    t_lookup();
    t_over();
    t_cdp();
    t_unmapped();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got %0d cycles expected completion", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule